// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to one of four 16-bit segment bases. The four bases are for code, stack, data and extra. Each base is scaled by sixteen before the addition, so every segment starts on a 16-byte boundary and covers 64 KB of offsets. Any carry past bit 19 is dropped, so the address space is a 1 MB ring.

The caller gives an offset and an access kind. The block picks the segment that goes with that kind. An override input can choose a different segment, except for string-destination accesses, which always use the extra segment. The bases are loaded through a synchronous write port.

The result is registered. It appears with a valid flag one clock after the request. The output holds its last value while no request is made.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears `addr_valid` and `addr_out` to zero and sets all four segment bases to 0000H. After reset, every access kind maps an offset X to physical address X.
- R2: The physical address equals (selected base × 16 + offset) taken modulo 2^20. For example, base 348AH with offset 4214H gives 38AB4H. The low four address bits always equal the low four offset bits.
- R3: A sum beyond FFFFFH wraps to the bottom of the space. Base FFFFH with offset 0020H gives 00010H, and base FFFFH with offset 000FH gives FFFFFH.
- R4: With the override off, `req_kind` picks the segment as follows: 0 (fetch) uses code, 1 (stack via SP) and 2 (stack via BP) use stack, 3 (data via SI) uses data, and 4 (string destination via DI) uses extra. The unused codes 5 to 7 use data.
- R5: When `ovr_en` is 1 and the kind is not 4, the segment named by `ovr_sel` is used instead of the default.
- R6: Kind 4 (string destination) always uses the extra segment, whatever the values of `ovr_en` and `ovr_sel`.
- R7: If a segment base is written in the same cycle as a request that uses it, that request sees the old base. Requests from the next cycle onward see the new base.
- R8: `addr_valid` is 1 exactly in the cycle after a cycle with `req_valid` = 1. After a cycle without a request, `addr_out` keeps its value.
- R9: When `wr_en` = 1, `wr_data` is loaded at the clock edge into the base chosen by `wr_sel`: 0 for code, 1 for stack, 2 for data, 3 for extra. The same 2-bit encoding is used by `ovr_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment base write enable |
| wr_sel | input | 2 | Segment to write (0 code, 1 stack, 2 data, 3 extra) |
| wr_data | input | 16 | New segment base value |
| req_valid | input | 1 | Address request this cycle |
| req_kind | input | 3 | Access kind code |
| req_offset | input | 16 | Offset within the segment |
| ovr_en | input | 1 | Use `ovr_sel` in place of the default segment |
| ovr_sel | input | 2 | Override segment |
| addr_valid | output | 1 | Registered address is valid |
| addr_out | output | 20 | Registered physical address |

## Verification
The assertions assume that `req_valid`, `req_kind`, `ovr_en` and `ovr_sel` are stable across each rising edge and never unknown. The stimulus meets this by changing every input only on the falling edge. The assertions also assume that the segment shift is four bits, so that the low nibble of the address follows the offset. The stimulus keeps the default parameters. Kind codes 5 to 7 are driven on purpose, to exercise their documented fallback to the data segment. Writes that collide with requests are driven only in sequences where the bench model applies the write after predicting that request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W     = 16;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = SEG_W + SEG_SHIFT;
    localparam int N_SEG     = 4;
    localparam int KIND_W    = 3;

    // Segment identifiers; the numeric values are the write/override encoding.
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_STACK = 2'd1,
        SEG_DATA  = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_t;

    // Access kind codes presented on req_kind.
    localparam logic [KIND_W-1:0] ACC_FETCH   = 3'd0;
    localparam logic [KIND_W-1:0] ACC_STK_SP  = 3'd1;
    localparam logic [KIND_W-1:0] ACC_STK_BP  = 3'd2;
    localparam logic [KIND_W-1:0] ACC_DATA_SI = 3'd3;
    localparam logic [KIND_W-1:0] ACC_STR_DI  = 3'd4;

    typedef struct packed {
        logic            valid;
        logic [PA_W-1:0] addr;
    } addr_resp_t;

    // Default segment for an access kind; unused codes fall back to data.
    function automatic seg_id_t default_seg(input logic [KIND_W-1:0] kind);
        seg_id_t s;
        case (kind)
            ACC_FETCH:              s = SEG_CODE;
            ACC_STK_SP, ACC_STK_BP: s = SEG_STACK;
            ACC_STR_DI:             s = SEG_EXTRA;
            default:                s = SEG_DATA;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_base_regs.sv
module seg_base_regs
    import seg_addr_pkg::*;
#(
    parameter int NUM   = N_SEG,
    parameter int WIDTH = SEG_W,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_sel,
    input  logic [WIDTH-1:0]           wr_data,
    output logic [NUM-1:0][WIDTH-1:0]  base_q
);

    for (genvar g = 0; g < NUM; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g] <= '0;
            end else if (wr_en && (wr_sel == IDX_W'(g))) begin
                base_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/seg_picker.sv
module seg_picker
    import seg_addr_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_sel,
    output seg_id_t           pick
);

    always_comb begin
        pick = default_seg(kind);
        // String destination is pinned to the extra segment.
        if (ovr_en && (kind != ACC_STR_DI)) begin
            pick = seg_id_t'(ovr_sel);
        end
    end

endmodule

// File: rtl/seg_addr_adder.sv
module seg_addr_adder #(
    parameter int BASE_W = 16,
    parameter int OFFS_W = 16,
    parameter int SHIFT  = 4,
    localparam int OUT_W = BASE_W + SHIFT
) (
    input  logic [BASE_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    output logic [OUT_W-1:0]  phys
);

    logic [OUT_W-1:0] scaled;
    logic [OUT_W-1:0] widened;

    assign scaled  = {base, {SHIFT{1'b0}}};
    assign widened = OUT_W'(offset);
    // Sum is truncated to OUT_W bits: the carry out wraps the space.
    assign phys    = scaled + widened;

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int OW = OFF_W,
    parameter int SH = SEG_SHIFT,
    localparam int AW = SW + SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [SW-1:0] wr_data,
    input  logic          req_valid,
    input  logic [2:0]    req_kind,
    input  logic [OW-1:0] req_offset,
    input  logic          ovr_en,
    input  logic [1:0]    ovr_sel,
    output logic          addr_valid,
    output logic [AW-1:0] addr_out
);

    logic [N_SEG-1:0][SW-1:0] base_q;
    seg_id_t                  pick_seg;
    logic [SW-1:0]            pick_base;
    logic [AW-1:0]            phys_next;
    addr_resp_t               resp_q;

    seg_base_regs #(.NUM(N_SEG), .WIDTH(SW)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .base_q (base_q)
    );

    seg_picker i_pick (
        .kind   (req_kind),
        .ovr_en (ovr_en),
        .ovr_sel(ovr_sel),
        .pick   (pick_seg)
    );

    // Reads the registered base, so a same-cycle write is not yet visible.
    assign pick_base = base_q[pick_seg];

    seg_addr_adder #(.BASE_W(SW), .OFFS_W(OW), .SHIFT(SH)) i_add (
        .base  (pick_base),
        .offset(req_offset),
        .phys  (phys_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= req_valid;
            if (req_valid) begin
                resp_q.addr <= phys_next;
            end
        end
    end

    assign addr_valid = resp_q.valid;
    assign addr_out   = resp_q.addr;

endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
    import seg_addr_pkg::*;
#(
    parameter int OW = OFF_W,
    parameter int SH = SEG_SHIFT,
    parameter int AW = PA_W
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [2:0]    req_kind,
    input logic [OW-1:0] req_offset,
    input logic          ovr_en,
    input logic [1:0]    ovr_sel,
    input seg_id_t       pick_seg,
    input logic          addr_valid,
    input logic [AW-1:0] addr_out
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!addr_valid && addr_out == '0)); // R1

    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (addr_out[SH-1:0] == $past(req_offset[SH-1:0]))); // R2

    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (rst)
        (!ovr_en && req_kind == ACC_FETCH) |-> (pick_seg == SEG_CODE)); // R4

    AST_OVERRIDE_USED: assert property (@(posedge clk) disable iff (rst)
        (ovr_en && req_kind != ACC_STR_DI) |-> (pick_seg == seg_id_t'(ovr_sel))); // R5

    AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (req_kind == ACC_STR_DI) |-> (pick_seg == SEG_EXTRA)); // R6

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> addr_valid); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !addr_valid); // R8

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(addr_out)); // R8

endmodule

bind seg_addr_gen seg_addr_gen_chk #(.OW(OW), .SH(SH), .AW(AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_offset(req_offset),
    .ovr_en    (ovr_en),
    .ovr_sel   (ovr_sel),
    .pick_seg  (pick_seg),
    .addr_valid(addr_valid),
    .addr_out  (addr_out)
);

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        addr_valid;
    logic [19:0] addr_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        bit          v;
        logic [19:0] a;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [15:0] model_base [4];
    logic [19:0] last_exp = '0;

    always #10 clk = ~clk; // 50 MHz

    seg_addr_gen i_seg_addr_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_offset(req_offset),
        .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .addr_valid(addr_valid), .addr_out(addr_out)
    );

    function automatic int model_pick(input logic [2:0] k, input bit oe, input logic [1:0] os);
        if (k == 3'd4) return 3;
        if (oe) return int'(os);
        case (k)
            3'd0:       return 0;
            3'd1, 3'd2: return 1;
            default:    return 2;
        endcase
    endfunction

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, pushes the expected result.
    task automatic drive(input bit v, input logic [2:0] k, input logic [15:0] off,
                         input bit oe, input logic [1:0] os,
                         input bit we, input logic [1:0] ws, input logic [15:0] wd,
                         input string tag);
        exp_t e;
        logic [19:0] sum;
        @(negedge clk);
        req_valid = v; req_kind = k; req_offset = off;
        ovr_en = oe; ovr_sel = os;
        wr_en = we; wr_sel = ws; wr_data = wd;
        if (v) begin
            sum = {model_base[model_pick(k, oe, os)], 4'h0} + {4'h0, off};
            last_exp = sum;
        end
        e.v = v; e.a = last_exp; e.tag = tag;
        sb_q.push_back(e);
        if (we) model_base[ws] = wd; // new base visible from next cycle (R7)
    endtask

    task automatic req(input logic [2:0] k, input logic [15:0] off, input string tag);
        drive(1'b1, k, off, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, tag);
    endtask

    task automatic ovr_req(input logic [2:0] k, input logic [15:0] off, input logic [1:0] os,
                           input string tag);
        drive(1'b1, k, off, 1'b1, os, 1'b0, 2'd0, 16'h0, tag);
    endtask

    task automatic wr(input logic [1:0] ws, input logic [15:0] wd, input string tag);
        drive(1'b0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b1, ws, wd, tag);
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, tag);
    endtask

    // Monitor: pops one item per cycle, a quarter period after the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check({e.tag, " valid"}, {19'h0, addr_valid}, {19'h0, e.v});
                check({e.tag, " addr"}, addr_out, e.a);
            end else if (!rst && addr_valid) begin
                check("R8 unexpected valid", {19'h0, addr_valid}, 20'h0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_base[i] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {19'h0, addr_valid}, 20'h0);
        check("R1 reset addr", addr_out, 20'h0);
        rst = 1'b0;

        // R1: zero bases after reset
        req(3'd0, 16'h1234, "R1 fetch zero base");
        req(3'd1, 16'hFFFF, "R1 stack zero base");
        req(3'd4, 16'h0042, "R1 strdst zero base");

        // R9 / R2: load code base, worked example
        wr(2'd0, 16'h348A, "R9 write code");
        req(3'd0, 16'h4214, "R2 fetch 348A:4214");

        // R4: default mapping per kind
        wr(2'd1, 16'h4000, "R9 write stack");
        wr(2'd2, 16'h1000, "R9 write data");
        wr(2'd3, 16'h2000, "R9 write extra");
        req(3'd1, 16'h9F20, "R4 stack via SP");
        req(3'd2, 16'h0010, "R4 stack via BP");
        req(3'd3, 16'h0005, "R4 data via SI");
        req(3'd4, 16'h0007, "R4 strdst via DI");
        req(3'd0, 16'h0001, "R4 fetch");
        req(3'd5, 16'h0003, "R4 unused kind 5");
        req(3'd7, 16'h0009, "R4 unused kind 7");

        // R5: override
        ovr_req(3'd0, 16'h0001, 2'd3, "R5 fetch override extra");
        ovr_req(3'd3, 16'h0002, 2'd1, "R5 data override stack");
        ovr_req(3'd1, 16'h0004, 2'd0, "R5 stack override code");
        // R6: string destination ignores override
        ovr_req(3'd4, 16'h0006, 2'd0, "R6 strdst ignores override");
        ovr_req(3'd4, 16'h0008, 2'd2, "R6 strdst ignores override 2");

        // R3: wrap
        wr(2'd2, 16'hFFFF, "R9 write data FFFF");
        req(3'd3, 16'h0020, "R3 wrap FFFF:0020");
        req(3'd3, 16'h000F, "R3 top FFFF:000F");
        req(3'd3, 16'hFFFF, "R3 wrap FFFF:FFFF");

        // R7: write colliding with request
        drive(1'b1, 3'd0, 16'h0000, 1'b0, 2'd0, 1'b1, 2'd0, 16'h5000, "R7 old base used");
        req(3'd0, 16'h0000, "R7 new base next cycle");

        // R8: hold and back-to-back
        idle("R8 hold 1");
        idle("R8 hold 2");
        req(3'd1, 16'h0001, "R8 b2b 1");
        req(3'd1, 16'h0002, "R8 b2b 2");
        wr(2'd1, 16'h0000, "R8 hold across write");
        idle("R8 hold 3");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule